// File: doc/BRIEF.md
# Host SRAM Access Sequencer

This block gives a local host processor single-word read and write access to an SRAM that several internal memory clients share. The host starts an access by pulling its select and strobe lines low. On that one clock edge the sequencer captures everything it needs: direction, bank, word, address, byte enables, write data and a wait-state setting. It then runs the access through a fixed cycle pattern and takes no further notice of the host pins until the pattern is over.

The pattern has five steps. The first is the sample edge. The second cycle asks a fixed-priority arbiter for the memory, and internal clients beat the host in that arbiter. Once the host holds the grant, one turnaround cycle always follows so the bus transceivers can switch. Then comes the data phase, which may be stretched by up to three wait cycles. The last data cycle carries the ready strobe, the read data or the write pulse. A final recovery cycle lets internal clients that queued up during the access be served. The block also drives a transceiver direction line and an active-low enable for the data and address buffers.

Top module: `hostSramSeq`

## Requirements
- R1: An access starts on a rising clock edge, seen while idle, at which both `hostCsN` and `hostAsN` are low. That edge captures `hostRdWrN` (1 = read, 0 = write), `hostBank`, `hostWord`, `hostAddr`, `hostBeN`, `hostWdata` and `cfgWait`.
- R2: After the start edge, changes on the host inputs have no effect on the running access. During the access `sramAddr` is `{bank, addr, word}` as captured, with bank in the top bits and word in the bottom bits.
- R3: In the cycle after the start edge (cycle 2) the request is arbitrated. With no internal request the host is granted and cycle 3 follows. If any `intReq` bit is high, that internal client is granted instead and the host keeps waiting.
- R4: The cycle after the host grant is always a turnaround cycle. In it `sramCeN` is low and `hostRdyN` is high, for reads and writes alike.
- R5: With `cfgWait` = 0, a read drives `hostRdyN` low in the cycle after turnaround, and `hostRdata` then carries the SRAM word at the captured address.
- R6: The data phase lasts `cfgWait`+1 cycles (`cfgWait` from 0 to 3). `hostRdyN` is low only in the last of them.
- R7: On a write, `sramWeN` is low only in the ready cycle, with `sramWdata` equal to the captured data and `sramBeN` equal to the captured `hostBeN` (bit i low enables byte lane i, lane 0 = bits 7:0). On a read, `hostBeN` is ignored: `sramBeN` is 0000 and the full word is returned.
- R8: The cycle after the ready cycle is a recovery cycle, in which `hostRdyN` is high and `sramCeN` is high. Internal requests are granted in that cycle. No internal grant is issued during turnaround or the data phase.
- R9: Select and strobe lines held low during an access are not sampled until the first idle cycle after recovery. The next access therefore starts on the edge that ends that idle cycle.
- R10: `daEnN` is low exactly during turnaround and the data phase. `xcvrToHost` is high during those cycles of a read and low otherwise.
- R11: Internal grants are fixed priority: the lowest-index asserted `intReq` wins. At most one grant (internal or host) is active in any cycle, and an internal grant may also be given while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostAsN | input | 1 | Host address strobe, active low |
| hostRdWrN | input | 1 | 1 = read, 0 = write |
| hostBank | input | BANK_W | Bank select |
| hostWord | input | WORD_W | Word select |
| hostAddr | input | ADDR_W | Host address |
| hostBeN | input | DATA_W/8 | Byte enables, active low |
| hostWdata | input | DATA_W | Write data |
| cfgWait | input | WAIT_W | Extra data-phase cycles (0 to 3) |
| hostRdata | output | DATA_W | Read data, valid with ready |
| hostRdyN | output | 1 | Ready strobe, active low |
| xcvrToHost | output | 1 | Transceiver direction, 1 = toward host |
| daEnN | output | 1 | Data/address buffer enable, active low |
| intReq | input | N_INT | Internal client requests |
| intGnt | output | N_INT | Internal client grants (one cycle each) |
| sramAddr | output | BANK_W+ADDR_W+WORD_W | SRAM address |
| sramCeN | output | 1 | SRAM chip enable, active low |
| sramOeN | output | 1 | SRAM output enable, active low |
| sramWeN | output | 1 | SRAM write enable, active low |
| sramBeN | output | DATA_W/8 | SRAM byte enables, active low |
| sramWdata | output | DATA_W | SRAM write data |
| sramRdata | input | DATA_W | SRAM read data |

## Verification
The bench scrambles every host input right after the start edge. A design that keeps sampling would then show the wrong address, byte enables or direction. It holds select and strobe low across a whole access, so an early resample in the recovery cycle would produce a second turnaround one cycle too soon. It raises an internal request in cycle 2 and again during the data phase. A host-first arbiter or a busy-blind grant then shows up directly on `intGnt` and on when `sramCeN` falls. Wait counts 1 to 3 and a partial-lane write, read back, catch off-by-one data phases and lane swaps.

// File: rtl/hss_pkg.sv
package hss_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_TURN,
    S_DATA,
    S_REC
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic busOn;
    logic rdPhase;
    logic wrStrobe;
    logic rdyOn;
  } seqStrobe_t;

endpackage

// File: rtl/hss_arb.sv
module hss_arb #(
  parameter int N_INT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_INT-1:0] intReq,
  input  logic             hostReq,
  input  logic             memFree,
  output logic [N_INT-1:0] intGnt,
  output logic             hostGnt
);

  logic taken;

  always_comb begin
    intGnt = '0;
    taken  = 1'b0;
    for (int i = 0; i < N_INT; i++) begin
      if (memFree && intReq[i] && !taken) begin
        intGnt[i] = 1'b1;
        taken     = 1'b1;
      end
    end
    hostGnt = memFree && hostReq && !taken;
  end

  // R11: never more than one grant
  a_r11_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intGnt, hostGnt}));

  // R3: an internal request in the arbitration cycle blocks the host
  a_r3_int_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && (|intReq)) |-> !hostGnt);

endmodule

// File: rtl/hss_ctrl.sv
module hss_ctrl
  import hss_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostAsN,
  input  logic              hostGnt,
  input  logic              isRead,
  input  logic [WAIT_W-1:0] waitLat,
  output logic              hostReq,
  output logic              memFree,
  output seqStrobe_t        strb
);

  seqState_t   state, stateNxt;
  logic [WAIT_W-1:0] cnt, cntNxt;
  logic        startHit;
  logic        lastData;

  assign startHit = (state == S_IDLE) && !hostCsN && !hostAsN;
  assign lastData = (state == S_DATA) && (cnt == waitLat);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      S_IDLE: if (startHit) stateNxt = S_ARB;
      S_ARB:  if (hostGnt)  stateNxt = S_TURN;
      S_TURN: begin
        stateNxt = S_DATA;
        cntNxt   = '0;
      end
      S_DATA: begin
        if (lastData) stateNxt = S_REC;
        else          cntNxt   = cnt + 1'b1;
      end
      S_REC:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign hostReq = (state == S_ARB);
  assign memFree = (state == S_IDLE) || (state == S_ARB) || (state == S_REC);

  always_comb begin
    strb.capture  = startHit;
    strb.busOn    = (state == S_TURN) || (state == S_DATA);
    strb.rdPhase  = strb.busOn && isRead;
    strb.rdyOn    = lastData;
    strb.wrStrobe = lastData && !isRead;
  end

  // R4: a host grant is always followed by the turnaround cycle
  a_r4_turn_after_gnt: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARB && hostGnt) |=> (state == S_TURN));

  // R4: turnaround lasts exactly one cycle and is followed by data
  a_r4_turn_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |=> (state == S_DATA));

  // R6: the data-phase counter never runs past the captured wait count
  a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA) |-> (cnt <= waitLat));

  // R8: the ready cycle is followed by recovery
  a_r8_rec_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    lastData |=> (state == S_REC));

  // R9: recovery always returns to idle before another start can be taken
  a_r9_rec_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REC) |=> (state == S_IDLE));

endmodule

// File: rtl/hss_dp.sv
module hss_dp
  import hss_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BANK_W = 2,
  parameter int WORD_W = 2,
  parameter int WAIT_W = 2,
  localparam int BE_W = DATA_W / 8,
  localparam int SA_W = BANK_W + ADDR_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              hostRdWrN,
  input  logic [BANK_W-1:0] hostBank,
  input  logic [WORD_W-1:0] hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BE_W-1:0]   hostBeN,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [WAIT_W-1:0] cfgWait,
  output logic              isRead,
  output logic [WAIT_W-1:0] waitLat,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRdyN,
  output logic              xcvrToHost,
  output logic              daEnN,
  output logic [SA_W-1:0]   sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [BE_W-1:0]   sramBeN,
  output logic [DATA_W-1:0] sramWdata,
  input  logic [DATA_W-1:0] sramRdata
);

  logic [SA_W-1:0]   addrLat;
  logic [BE_W-1:0]   beLat;
  logic [DATA_W-1:0] dataLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isRead  <= 1'b1;
      addrLat <= '0;
      beLat   <= '1;
      dataLat <= '0;
      waitLat <= '0;
    end else if (strb.capture) begin
      isRead  <= hostRdWrN;
      addrLat <= {hostBank, hostAddr, hostWord};
      beLat   <= hostBeN;
      dataLat <= hostWdata;
      waitLat <= cfgWait;
    end
  end

  assign sramAddr   = strb.busOn ? addrLat : '0;
  assign sramCeN    = !strb.busOn;
  assign sramOeN    = !strb.rdPhase;
  assign sramWeN    = !strb.wrStrobe;
  assign sramWdata  = dataLat;
  assign sramBeN    = !strb.busOn ? '1 : (isRead ? '0 : beLat);
  assign hostRdyN   = !strb.rdyOn;
  assign hostRdata  = (strb.rdPhase && strb.rdyOn) ? sramRdata : '0;
  assign xcvrToHost = strb.rdPhase;
  assign daEnN      = !strb.busOn;

  // R7: write enable only with ready and never together with output enable
  a_r7_we_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!hostRdyN && sramOeN && !sramCeN));

  // R2: the SRAM address holds for the whole access
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R10: the direction line only points toward the host while buffers are on
  a_r10_dir_in_window: assert property (@(posedge clk) disable iff (!rstN)
    xcvrToHost |-> !daEnN);

endmodule

// File: rtl/hostSramSeq.sv
module hostSramSeq
  import hss_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BANK_W = 2,
  parameter int WORD_W = 2,
  parameter int WAIT_W = 2,
  parameter int N_INT  = 2,
  localparam int BE_W = DATA_W / 8,
  localparam int SA_W = BANK_W + ADDR_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostAsN,
  input  logic              hostRdWrN,
  input  logic [BANK_W-1:0] hostBank,
  input  logic [WORD_W-1:0] hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BE_W-1:0]   hostBeN,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [WAIT_W-1:0] cfgWait,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRdyN,
  output logic              xcvrToHost,
  output logic              daEnN,
  input  logic [N_INT-1:0]  intReq,
  output logic [N_INT-1:0]  intGnt,
  output logic [SA_W-1:0]   sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [BE_W-1:0]   sramBeN,
  output logic [DATA_W-1:0] sramWdata,
  input  logic [DATA_W-1:0] sramRdata
);

  seqStrobe_t        strb;
  logic              hostReq;
  logic              memFree;
  logic              hostGnt;
  logic              isRead;
  logic [WAIT_W-1:0] waitLat;

  hss_arb #(.N_INT(N_INT)) u_arb (
    .clk     (clk),
    .rstN    (rstN),
    .intReq  (intReq),
    .hostReq (hostReq),
    .memFree (memFree),
    .intGnt  (intGnt),
    .hostGnt (hostGnt)
  );

  hss_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostCsN (hostCsN),
    .hostAsN (hostAsN),
    .hostGnt (hostGnt),
    .isRead  (isRead),
    .waitLat (waitLat),
    .hostReq (hostReq),
    .memFree (memFree),
    .strb    (strb)
  );

  hss_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .WORD_W(WORD_W), .WAIT_W(WAIT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostRdWrN  (hostRdWrN),
    .hostBank   (hostBank),
    .hostWord   (hostWord),
    .hostAddr   (hostAddr),
    .hostBeN    (hostBeN),
    .hostWdata  (hostWdata),
    .cfgWait    (cfgWait),
    .isRead     (isRead),
    .waitLat    (waitLat),
    .hostRdata  (hostRdata),
    .hostRdyN   (hostRdyN),
    .xcvrToHost (xcvrToHost),
    .daEnN      (daEnN),
    .sramAddr   (sramAddr),
    .sramCeN    (sramCeN),
    .sramOeN    (sramOeN),
    .sramWeN    (sramWeN),
    .sramBeN    (sramBeN),
    .sramWdata  (sramWdata),
    .sramRdata  (sramRdata)
  );

  // R8: no internal grant while the host owns the SRAM bus
  a_r8_busy_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> (intGnt == '0));

endmodule

// File: tb/hostSramSeq_bench.sv
module hostSramSeq_bench;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int SAW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1, asN = 1'b1, rdWrN = 1'b1;
  logic [1:0]    bank = '0, word = '0, cfgWait = '0, intReq = '0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    beN = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] hostRdata, sramWdata, sramRdata;
  logic          hostRdyN, xcvrToHost, daEnN, sramCeN, sramOeN, sramWeN;
  logic [1:0]    intGnt;
  logic [SAW-1:0] sramAddr;
  logic [3:0]    sramBeN;

  logic [DW-1:0] mem [256];

  int totalCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  hostSramSeq u_hostSramSeq (
    .clk(clk), .rstN(rstN), .hostCsN(csN), .hostAsN(asN), .hostRdWrN(rdWrN),
    .hostBank(bank), .hostWord(word), .hostAddr(addr), .hostBeN(beN),
    .hostWdata(wdata), .cfgWait(cfgWait), .hostRdata(hostRdata),
    .hostRdyN(hostRdyN), .xcvrToHost(xcvrToHost), .daEnN(daEnN),
    .intReq(intReq), .intGnt(intGnt), .sramAddr(sramAddr), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBeN(sramBeN),
    .sramWdata(sramWdata), .sramRdata(sramRdata)
  );

  assign sramRdata = mem[sramAddr];

  always @(posedge clk) begin
    if (!sramCeN && !sramWeN)
      for (int l = 0; l < 4; l++)
        if (!sramBeN[l]) mem[sramAddr][l*8 +: 8] <= sramWdata[l*8 +: 8];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives a start and scrambles every host input right after the sample edge.
  // Returns at the falling edge inside cycle 2.
  task automatic launch(input logic rd, input logic [1:0] b, input logic [1:0] w,
                        input logic [AW-1:0] a, input logic [3:0] be,
                        input logic [DW-1:0] d, input logic [1:0] wt);
    @(negedge clk);
    csN = 1'b0; asN = 1'b0; rdWrN = rd; bank = b; word = w; addr = a;
    beN = be; wdata = d; cfgWait = wt;
    @(posedge clk);
    @(negedge clk);
    csN = 1'b1; asN = 1'b1; rdWrN = ~rd; bank = ~b; word = ~w; addr = ~a;
    beN = ~be; wdata = ~d; cfgWait = ~wt;
  endtask

  task automatic testReset;
    chk("R8 reset ready idle", hostRdyN, 1'b1);
    chk("R10 reset daEnN", daEnN, 1'b1);
    chk("R8 reset sramCeN", sramCeN, 1'b1);
    chk("R11 reset grants", intGnt, 2'b00);
  endtask

  task automatic testRead;
    mem[{2'd2, 4'd5, 2'd1}] = 32'hA5A5_1234;
    launch(1'b1, 2'd2, 2'd1, 4'd5, 4'b1111, 32'h0, 2'd0);
    chk("R3 cycle2 bus off", sramCeN, 1'b1);
    @(negedge clk);
    chk("R4 turnaround ce", sramCeN, 1'b0);
    chk("R4 turnaround no ready", hostRdyN, 1'b1);
    chk("R10 read dir", xcvrToHost, 1'b1);
    chk("R10 daEnN on", daEnN, 1'b0);
    chk("R2 address after scramble", sramAddr, {2'd2, 4'd5, 2'd1});
    @(negedge clk);
    chk("R5 ready cycle4", hostRdyN, 1'b0);
    chk("R5 read data", hostRdata, 32'hA5A5_1234);
    chk("R7 read ignores be", sramBeN, 4'b0000);
    @(negedge clk);
    chk("R8 recovery no ready", hostRdyN, 1'b1);
    chk("R10 recovery daEnN off", daEnN, 1'b1);
    chk("R10 recovery dir", xcvrToHost, 1'b0);
    @(negedge clk);
  endtask

  task automatic testWrite;
    logic [SAW-1:0] a;
    a = {2'd1, 4'd9, 2'd3};
    mem[a] = 32'h1122_3344;
    launch(1'b0, 2'd1, 2'd3, 4'd9, 4'b0101, 32'hAABB_CCDD, 2'd0);
    @(negedge clk);
    chk("R4 write turnaround we off", sramWeN, 1'b1);
    chk("R4 write turnaround no ready", hostRdyN, 1'b1);
    chk("R10 write dir", xcvrToHost, 1'b0);
    @(negedge clk);
    chk("R7 we with ready", {sramWeN, hostRdyN}, 2'b00);
    chk("R7 lanes", sramBeN, 4'b0101);
    chk("R7 wdata", sramWdata, 32'hAABB_CCDD);
    chk("R1 write address", sramAddr, a);
    @(negedge clk);
    chk("R8 write recovery we off", sramWeN, 1'b1);
    chk("R7 merged word", mem[a], 32'hAA22_CC44);
    @(negedge clk);
  endtask

  task automatic testWaits;
    for (int wt = 1; wt < 4; wt++) begin
      mem[{2'd0, 4'd3, 2'd2}] = 32'h0000_0100 + wt;
      launch(1'b1, 2'd0, 2'd2, 4'd3, 4'b0000, 32'h0, wt[1:0]);
      @(negedge clk);
      for (int c = 0; c <= wt; c++) begin
        @(negedge clk);
        chk("R6 ready only in last data cycle", hostRdyN, (c == wt) ? 1'b0 : 1'b1);
        chk("R6 bus held in data phase", sramCeN, 1'b0);
      end
      chk("R6 stretched read data", hostRdata, 32'h0000_0100 + wt);
      @(negedge clk);
      chk("R8 recovery after stretch", {sramCeN, hostRdyN}, 2'b11);
      @(negedge clk);
    end
  endtask

  task automatic testContention;
    launch(1'b1, 2'd3, 2'd0, 4'd1, 4'b0000, 32'h0, 2'd0);
    intReq = 2'b10;
    #1;
    chk("R3 internal wins cycle2", intGnt, 2'b10);
    @(negedge clk);
    intReq = 2'b00;
    chk("R3 host still waiting", sramCeN, 1'b1);
    @(negedge clk);
    chk("R4 delayed turnaround", {sramCeN, hostRdyN}, 2'b01);
    @(negedge clk);
    chk("R5 delayed ready", hostRdyN, 1'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testRecoveryGrant;
    launch(1'b1, 2'd0, 2'd0, 4'd0, 4'b0000, 32'h0, 2'd0);
    @(negedge clk);
    intReq = 2'b11;
    #1;
    chk("R8 no grant in turnaround", intGnt, 2'b00);
    @(negedge clk);
    chk("R8 no grant in data", intGnt, 2'b00);
    @(negedge clk);
    chk("R11 recovery priority", intGnt, 2'b01);
    intReq = 2'b10;
    #1;
    chk("R8 recovery grants index1", intGnt, 2'b10);
    @(negedge clk);
    intReq = 2'b00;
  endtask

  task automatic testIdlePriority;
    @(negedge clk);
    intReq = 2'b11;
    #1;
    chk("R11 idle lowest index", intGnt, 2'b01);
    intReq = 2'b10;
    #1;
    chk("R11 idle single", intGnt, 2'b10);
    intReq = 2'b00;
  endtask

  task automatic testHoldoff;
    int rdyLows;
    rdyLows = 0;
    @(negedge clk);
    csN = 1'b0; asN = 1'b0; rdWrN = 1'b1; bank = 2'd1; word = 2'd1; addr = 4'd2;
    cfgWait = 2'd0;
    @(posedge clk);
    for (int c = 2; c <= 5; c++) begin
      @(negedge clk);
      if (!hostRdyN) rdyLows++;
    end
    chk("R9 one ready per access", rdyLows, 1);
    @(negedge clk);
    chk("R9 idle cycle before resample", sramCeN, 1'b1);
    @(negedge clk);
    chk("R9 arbitration after idle", sramCeN, 1'b1);
    csN = 1'b1; asN = 1'b1;
    @(negedge clk);
    chk("R1 second access turnaround", sramCeN, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 back to idle", daEnN, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead();
    testWrite();
    testWaits();
    testContention();
    testRecoveryGrant();
    testIdlePriority();
    testHoldoff();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule